// File: doc/BRIEF.md
# Binary Arithmetic Bin Decoder

This block is the arithmetic core of a context-adaptive binary arithmetic decoder, built to sit beside a bitstream processor as an execution unit. The surrounding processor issues one command at a time: an init command that primes the engine from the stream, a context-coded decode that takes a packed context word and returns both a bin and the updated context word, or an equiprobable decode that returns just a bin. The context word lives in the processor's registers. The engine itself holds only the arithmetic range and offset.

Probability data comes from a table memory that software loads. Reloading that memory switches the engine to another standard's tables without any hardware change. Each state index selects one table word. That word holds four LPS sub-ranges plus the two successor states, and it is read through a port with one cycle of latency. Stream bits come from an external shift register. The engine looks at that register's head window. In the same cycle as each update, it reports how many bits it used, so the register can drop those bits and realign before the next command.

Top module: `cabac_bin_decoder`

## Requirements
- R1: Command code 0 (init) sets the range to 510, loads the offset from the first 9 head bits (MSB of `bs_head` is the next stream bit), and consumes exactly 9 bits.
- R2: Command code 1 (context decode) takes a context word with the MPS in bit 6 and the state in bits 5:0. It selects the sub-range rLPS with q = range bits 7:6 and forms rMPS = range - rLPS. If offset >= rMPS, the output bin is the inverted MPS, the offset is reduced by rMPS and the range becomes rLPS. Otherwise the output bin is the MPS and the range becomes rMPS.
- R3: On an MPS result, the returned context keeps its MPS and takes the MPS successor state. On an LPS result, it takes the LPS successor state, and the MPS is inverted only when the incoming state is 0.
- R4: After a context decode, the range is renormalised in one step to a value of at least 256. The number of doublings is exactly the number of stream bits shifted into the offset and reported as consumed.
- R5: Command code 2 (equiprobable decode) forms 2*offset plus the next stream bit. If that value is >= range, the bin is 1 and the range is subtracted; otherwise the bin is 0. The range is unchanged, and exactly one bit is consumed.
- R6: Init and equiprobable decodes never assert the table read enable.
- R7: A context decode reads the table word at address = state. The word layout is: bits [8q+7:8q] hold rLPS for q=0..3, bits 37:32 hold the MPS successor, and bits 43:38 hold the LPS successor. The data is used one cycle after the read.
- R8: `done` rises one cycle after an accepted init or equiprobable command, and two cycles after an accepted context decode. `busy` is high during the second of those cycles. A start given while busy, or a start with code 3, is ignored.
- R9: Decode results follow the current table memory contents, so reloading the tables changes the results with no other action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | Command strobe, accepted when not busy |
| cmd_op | input | 2 | 0 init, 1 context decode, 2 equiprobable decode, 3 ignored |
| ctx_in | input | 7 | Context word {mps, state} |
| busy | output | 1 | Context decode in its execute cycle |
| done | output | 1 | One-cycle completion pulse |
| bin_out | output | 1 | Decoded bin |
| ctx_out | output | 7 | Updated context word |
| tbl_rd_en | output | 1 | Table read enable |
| tbl_addr | output | 6 | Table word address (state) |
| tbl_rdata | input | 44 | Table word, valid one cycle after the read |
| bs_head | input | 16 | Head window of the bitstream register |
| bs_adv | output | 1 | Consume strobe to the bitstream register |
| bs_nbits | output | 4 | Number of bits consumed |

## Verification
Init and equiprobable results are due at the first falling edge after the accepting clock edge. Context decode results are due one edge later, because the table word must first arrive through the one-cycle read port. The bench drives a command at a falling edge and counts falling edges until `done`. It compares that count with 1 or 2 and reads `bin_out`, `ctx_out` and its own stream pointer at that edge. Before the accepting edge, it samples the read enable and address to confirm which commands touch the table memory.

// File: rtl/cabac_pkg.sv
// Shared command codes and controller states for the bin decoder.
// Assumes a 2-bit command field issued by the host processor.
package cabac_pkg;
    typedef enum logic [1:0] {
        OP_INIT = 2'd0,
        OP_CTX  = 2'd1,
        OP_EQP  = 2'd2,
        OP_NONE = 2'd3
    } op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EXEC = 1'b1
    } fsm_e;
endpackage

// File: rtl/cabac_lzc.sv
// Leading-zero counter for the renormalisation shift.
// Counts the zero bits above the most significant one of a W-bit value.
// Returns W for an all-zero input.
module cabac_lzc #(
    parameter int W   = 9,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  val,
    output logic [CW-1:0] zeros
);
    // Scan from the LSB upward, so the highest set bit wins last.
    always_comb begin
        zeros = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (val[i]) zeros = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/cabac_arith_core.sv
// Range/offset datapath of the bin decoder.
// Performs the init load, the context-coded decision with one-step
// renormalisation, and the equiprobable decision.
// Assumes the head window holds at least RANGE_W valid bits,
// and that at most one of the do_* strobes is high in a cycle.
module cabac_arith_core #(
    parameter int RANGE_W = 9,
    parameter int HEAD_W  = 16,
    localparam int NB_W   = $clog2(RANGE_W + 1),
    localparam logic [RANGE_W-1:0] RANGE_INIT = RANGE_W'((1 << RANGE_W) - 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               do_init,
    input  logic               do_ctx,
    input  logic               do_eqp,
    input  logic               mps_in,
    input  logic [RANGE_W-1:0] rlps,
    input  logic [HEAD_W-1:0]  head,
    output logic [RANGE_W-1:0] range_q,
    output logic               bin,
    output logic               is_lps,
    output logic [NB_W-1:0]    nbits
);
    logic [RANGE_W-1:0]   offset_q;
    logic [RANGE_W-1:0]   rmps, r_sel, o_sel, ctx_rng, ctx_off, eqp_off;
    logic [NB_W-1:0]      shamt;
    logic [2*RANGE_W-1:0] joined;
    logic [RANGE_W:0]     eqp_ext;
    logic                 eqp_ge;

    // Context-coded decision between the LPS and MPS sub-ranges.
    always_comb begin
        rmps   = range_q - rlps;
        is_lps = (offset_q >= rmps);
        r_sel  = is_lps ? rlps : rmps;
        o_sel  = is_lps ? (offset_q - rmps) : offset_q;
    end

    cabac_lzc #(.W(RANGE_W)) u_lzc (.val(r_sel), .zeros(shamt));

    // One-step renormalisation: shift range and offset, pulling bits from the head.
    always_comb begin
        joined  = {o_sel, head[HEAD_W-1 -: RANGE_W]} << shamt;
        ctx_off = joined[2*RANGE_W-1 -: RANGE_W];
        ctx_rng = r_sel << shamt;
    end

    // Equiprobable decision with one new stream bit.
    always_comb begin
        eqp_ext = {offset_q, head[HEAD_W-1]};
        eqp_ge  = (eqp_ext >= {1'b0, range_q});
        eqp_off = eqp_ge ? RANGE_W'(eqp_ext - {1'b0, range_q}) : eqp_ext[RANGE_W-1:0];
    end

    // Result bin and consumed-bit count for the active command.
    always_comb begin
        bin   = do_ctx ? (is_lps ? ~mps_in : mps_in) : eqp_ge;
        nbits = do_init ? NB_W'(RANGE_W) : (do_ctx ? shamt : NB_W'(1));
    end

    // Arithmetic state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            range_q  <= RANGE_INIT;
            offset_q <= '0;
        end else if (do_init) begin
            range_q  <= RANGE_INIT;
            offset_q <= head[HEAD_W-1 -: RANGE_W];
        end else if (do_ctx) begin
            range_q  <= ctx_rng;
            offset_q <= ctx_off;
        end else if (do_eqp) begin
            offset_q <= eqp_off;
        end
    end

    a_r4_range_norm: assert property (@(posedge clk) disable iff (!rst_n)
        range_q[RANGE_W-1]);
    a_r1_init_load: assert property (@(posedge clk) disable iff (!rst_n)
        do_init |=> (range_q == RANGE_INIT) && (offset_q == $past(head[HEAD_W-1 -: RANGE_W])));
    a_r5_eqp_range_kept: assert property (@(posedge clk) disable iff (!rst_n)
        do_eqp |=> $stable(range_q));
endmodule

// File: rtl/cabac_bin_decoder.sv
// Top of the bin decoder: command acceptance, table read, context update.
// A context decode reads the table word for its state, then executes
// one cycle later when the word arrives. Init and equiprobable commands
// execute in the accepting cycle. The consume strobe is combinational,
// so the bitstream register realigns on the same edge as the update.
module cabac_bin_decoder #(
    parameter int STATE_W = 6,
    parameter int RANGE_W = 9,
    parameter int LPS_W   = 8,
    parameter int HEAD_W  = 16,
    localparam int CTX_W  = STATE_W + 1,
    localparam int TBL_W  = 4 * LPS_W + 2 * STATE_W,
    localparam int NB_W   = $clog2(RANGE_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_start,
    input  logic [1:0]         cmd_op,
    input  logic [CTX_W-1:0]   ctx_in,
    output logic               busy,
    output logic               done,
    output logic               bin_out,
    output logic [CTX_W-1:0]   ctx_out,
    output logic               tbl_rd_en,
    output logic [STATE_W-1:0] tbl_addr,
    input  logic [TBL_W-1:0]   tbl_rdata,
    input  logic [HEAD_W-1:0]  bs_head,
    output logic               bs_adv,
    output logic [NB_W-1:0]    bs_nbits
);
    import cabac_pkg::*;

    fsm_e               st_q;
    logic [CTX_W-1:0]   ctx_q;
    logic               accept, do_init, do_ctx, do_eqp;
    logic [RANGE_W-1:0] range_q, rlps;
    logic [1:0]         qidx;
    logic               core_bin, core_lps;
    logic [STATE_W-1:0] succ_mps, succ_lps, cur_state;
    logic               cur_mps;
    logic [CTX_W-1:0]   ctx_next;

    // Command decode: starts are taken only while idle.
    always_comb begin
        accept    = (st_q == ST_IDLE) && cmd_start;
        do_init   = accept && (cmd_op == OP_INIT);
        do_eqp    = accept && (cmd_op == OP_EQP);
        tbl_rd_en = accept && (cmd_op == OP_CTX);
        tbl_addr  = ctx_in[STATE_W-1:0];
        do_ctx    = (st_q == ST_EXEC);
        busy      = (st_q == ST_EXEC);
    end

    // Field extraction from the arriving table word.
    always_comb begin
        qidx      = range_q[RANGE_W-2 -: 2];
        rlps      = RANGE_W'(tbl_rdata[qidx*LPS_W +: LPS_W]);
        succ_mps  = tbl_rdata[4*LPS_W +: STATE_W];
        succ_lps  = tbl_rdata[4*LPS_W+STATE_W +: STATE_W];
        cur_state = ctx_q[STATE_W-1:0];
        cur_mps   = ctx_q[STATE_W];
    end

    cabac_arith_core #(.RANGE_W(RANGE_W), .HEAD_W(HEAD_W)) u_core (
        .clk(clk), .rst_n(rst_n),
        .do_init(do_init), .do_ctx(do_ctx), .do_eqp(do_eqp),
        .mps_in(cur_mps), .rlps(rlps), .head(bs_head),
        .range_q(range_q), .bin(core_bin), .is_lps(core_lps), .nbits(bs_nbits)
    );

    // Successor context word.
    always_comb begin
        if (core_lps)
            ctx_next = {cur_mps ^ (cur_state == '0), succ_lps};
        else
            ctx_next = {cur_mps, succ_mps};
        bs_adv = do_init || do_eqp || do_ctx;
    end

    // Controller state and registered results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            ctx_q   <= '0;
            done    <= 1'b0;
            bin_out <= 1'b0;
            ctx_out <= '0;
        end else begin
            done <= do_init || do_eqp || do_ctx;
            if (tbl_rd_en) begin
                st_q  <= ST_EXEC;
                ctx_q <= ctx_in;
            end else if (do_ctx) begin
                st_q <= ST_IDLE;
            end
            if (do_eqp || do_ctx) bin_out <= core_bin;
            if (do_ctx) ctx_out <= ctx_next;
        end
    end

    a_r7_read_then_exec: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_rd_en |=> busy);
    a_r8_exec_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);
    a_r6_no_read_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !tbl_rd_en);
    a_r3_mps_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !core_lps) |=> ctx_out[STATE_W] == $past(ctx_q[STATE_W]));
endmodule

// File: tb/cabac_bin_decoder_tb.sv
// Self-checking bench: sweeps every context word under two table sets,
// interleaving equiprobable decodes, against an arithmetic model.
module cabac_bin_decoder_tb;
    localparam int CLK_P = 10;
    localparam int NBITS = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [6:0]  ctx_in = '0;
    logic        busy, done, bin_out, tbl_rd_en, bs_adv;
    logic [6:0]  ctx_out;
    logic [5:0]  tbl_addr;
    logic [43:0] tbl_rdata;
    logic [15:0] bs_head;
    logic [3:0]  bs_nbits;

    logic [43:0] tmem [64];
    logic        sbits [NBITS];
    int          pos, rpos;
    int          m_rng, m_off;
    int          n_run = 0, n_fail = 0;
    bit          finished = 0;

    always #(CLK_P/2) clk = ~clk;

    cabac_bin_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_op(cmd_op),
        .ctx_in(ctx_in), .busy(busy), .done(done), .bin_out(bin_out),
        .ctx_out(ctx_out), .tbl_rd_en(tbl_rd_en), .tbl_addr(tbl_addr),
        .tbl_rdata(tbl_rdata), .bs_head(bs_head), .bs_adv(bs_adv),
        .bs_nbits(bs_nbits)
    );

    // Table memory with one cycle of read latency.
    always @(posedge clk) if (tbl_rd_en) tbl_rdata <= tmem[tbl_addr];

    // Bitstream register: drops consumed bits on the update edge.
    always @(posedge clk) begin
        if (!rst_n) pos <= 0;
        else if (bs_adv) pos <= pos + int'(bs_nbits);
    end
    always_comb for (int i = 0; i < 16; i++) bs_head[15-i] = sbits[(pos + i) % NBITS];

    function automatic logic [43:0] mk_word(input int set, input int s);
        logic [43:0] w;
        int ms, ls;
        for (int q = 0; q < 4; q++) begin
            if (set == 0) w[q*8 +: 8] = 8'(2 + ((126 + 32*q) * (63 - s)) / 63);
            else          w[q*8 +: 8] = 8'(3 + ((100 + 40*q) * (63 - s)) / 63);
        end
        ms = (set == 0) ? ((s + 1 > 62) ? 62 : s + 1) : ((s + 2 > 62) ? 62 : s + 2);
        ls = (set == 0) ? s / 2 : ((s > 3) ? s - 3 : 0);
        w[37:32] = 6'(ms);
        w[43:38] = 6'(ls);
        return w;
    endfunction

    task automatic load_tables(input int set);
        for (int s = 0; s < 64; s++) tmem[s] = mk_word(set, s);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int nextbit();
        int b = int'(sbits[rpos % NBITS]);
        rpos++;
        return b;
    endfunction

    // Issue one command, model it, and check the results at the due edge.
    task automatic run_op(input int op, input int ctx);
        int exp_bin, exp_ctx, exp_lat, lat, s, m, q, rl, rm, w;
        s = ctx & 63; m = (ctx >> 6) & 1;
        exp_bin = 0; exp_ctx = 0;
        @(negedge clk);
        cmd_start = 1'b1; cmd_op = 2'(op); ctx_in = 7'(ctx);
        #1;
        if (op == 1) begin
            chk(tbl_rd_en == 1'b1, "R7 read enable", int'(tbl_rd_en), 1);
            chk(tbl_addr == 6'(s), "R7 read address", int'(tbl_addr), s);
        end else begin
            chk(tbl_rd_en == 1'b0, "R6 no table read", int'(tbl_rd_en), 0);
        end
        if (op == 0) begin
            m_rng = 510; m_off = 0;
            for (int i = 0; i < 9; i++) m_off = (m_off << 1) | nextbit();
        end else if (op == 1) begin
            q  = (m_rng >> 6) & 3;
            rl = int'(tmem[s][q*8 +: 8]);
            rm = m_rng - rl;
            if (m_off >= rm) begin
                exp_bin = 1 - m; m_off -= rm; m_rng = rl;
                exp_ctx = (((s == 0) ? 1 - m : m) << 6) | int'(tmem[s][43:38]);
            end else begin
                exp_bin = m; m_rng = rm;
                exp_ctx = (m << 6) | int'(tmem[s][37:32]);
            end
            while (m_rng < 256) begin
                m_rng = m_rng << 1;
                m_off = (m_off << 1) | nextbit();
            end
        end else if (op == 2) begin
            w = (m_off << 1) | nextbit();
            if (w >= m_rng) begin exp_bin = 1; m_off = w - m_rng; end
            else begin exp_bin = 0; m_off = w; end
        end
        exp_lat = (op == 1) ? 2 : 1;
        @(negedge clk);
        // R8: during a context decode a second start is held and must be ignored.
        if (op == 1) begin
            cmd_start = 1'b1; cmd_op = 2'd2;
            chk(busy == 1'b1, "R8 busy in execute", int'(busy), 1);
        end else begin
            cmd_start = 1'b0;
        end
        lat = 1;
        while (!done && lat < 4) begin
            @(negedge clk);
            cmd_start = 1'b0;
            lat++;
        end
        cmd_start = 1'b0;
        if (op == 3) begin
            chk(done == 1'b0, "R8 code 3 ignored", int'(done), 0);
        end else begin
            chk(lat == exp_lat, "R8 done latency", lat, exp_lat);
            if (op == 1) begin
                chk(int'(bin_out) == exp_bin, "R2 context bin", int'(bin_out), exp_bin);
                chk(int'(ctx_out) == exp_ctx, "R3 context word", int'(ctx_out), exp_ctx);
            end
            if (op == 2) chk(int'(bin_out) == exp_bin, "R5 equiprobable bin", int'(bin_out), exp_bin);
        end
        chk(pos == rpos, (op == 0) ? "R1 init consume" : (op == 1) ? "R4 renorm consume" :
            (op == 2) ? "R5 one bit consumed" : "R8 code 3 consume", pos, rpos);
    endtask

    initial begin
        int lf = 16'hACE1;
        for (int i = 0; i < NBITS; i++) begin
            sbits[i] = lf[0];
            lf = (lf >> 1) ^ ((lf & 1) ? 16'hB400 : 0);
        end
        load_tables(0);
        rpos = 0; m_rng = 510; m_off = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R8 reset idle", int'(done | busy), 0);
        chk(bs_adv == 1'b0 && tbl_rd_en == 1'b0, "R6 reset quiet", int'(bs_adv | tbl_rd_en), 0);
        for (int set = 0; set < 2; set++) begin
            // R9: new table contents take effect with no other action.
            load_tables(set);
            run_op(0, 0);
            for (int c = 0; c < 128; c++) begin
                run_op(1, c);
                run_op(2, 0);
                if (c % 32 == 5) run_op(3, 0);
                if (c % 40 == 39) run_op(0, 0);
            end
        end
        for (int k = 0; k < 16; k++) run_op(2, 0);
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule